// File: doc/BRIEF.md
# Inclusive Two-Level Tag Hierarchy Controller

This block keeps the tags for a small private first-level cache and a larger second-level cache and holds them in a strictly inclusive relation: any line tagged in the first level is also tagged in the second. It stores no data. It only decides where a lookup would be served from and how the two tag arrays must change. A requester presents one line address. Two cycles later the block reports the result: a first-level hit, a second-level hit, or a fetch from memory. It also reports the fills and evictions that the lookup caused at each level.

Both levels are fully associative and use least-recently-used replacement. When the first level must make room, its victim is simply dropped, because the second level still holds that line. When the second level must make room on a memory fetch, its victim is also removed from the first level if present (back-invalidation). That removal happens before the new line is placed in the first level, so the freed slot takes the new line.

Top module: `incl_cache_tags`

## Requirements
- R1: After reset both levels hold no lines, `req_ready` is 1, `rsp_valid` is 0, and the first lookup of any address reports a memory fetch.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 for the following cycle. `rsp_valid` is 1 for exactly one cycle, starting at the second edge after acceptance.
- R3: While `rsp_valid` is 1, exactly one of `rsp_hit_l1`, `rsp_hit_l2` and `rsp_miss` is 1. The event outputs (fills, evictions, back-invalidation, evicted addresses) read 0 whenever `rsp_valid` is 0 and whenever they are not set.
- R4: A first-level hit causes no fill, no eviction and no back-invalidation. It makes the line most recently used in the first level only.
- R5: A first-level miss that hits the second level sets `rsp_l1_fill` and installs the line in the first level. It causes no second-level fill or eviction, and it makes the line most recently used in the second level.
- R6: A miss in both levels sets `rsp_l1_fill` and `rsp_l2_fill` and installs the line in both levels as most recently used.
- R7: When the first level has no free slot on a fill, its least recently used line is dropped. The drop sets `rsp_l1_evict` with that address on `rsp_l1_evict_addr`. The dropped line stays in the second level, so a later lookup of it reports a second-level hit.
- R8: When a memory fetch finds the second level full, its least recently used line is evicted. The eviction sets `rsp_l2_evict` with that address on `rsp_l2_evict_addr`. If that line is in the first level, it is removed there and `rsp_backinv` is set. The new line then takes the freed slot with no first-level capacity eviction.
- R9: At every cycle every valid first-level tag matches a valid second-level tag. A line evicted from the second level therefore reports a memory fetch on its next lookup.
- R10: A request presented while `req_ready` is 0 is ignored. It changes neither level and produces no response.
- R11: Recency at each level is updated only by a hit or an install at that level. A hit in the first level does not refresh the second level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | LINE_W (12) | Line address of the lookup |
| req_ready | output | 1 | Block idle, request can be accepted |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_hit_l1 | output | 1 | Lookup hit the first level |
| rsp_hit_l2 | output | 1 | Lookup missed the first level, hit the second |
| rsp_miss | output | 1 | Lookup went to memory |
| rsp_l1_fill | output | 1 | Line installed in the first level |
| rsp_l2_fill | output | 1 | Line installed in the second level |
| rsp_l1_evict | output | 1 | First-level capacity victim dropped |
| rsp_l1_evict_addr | output | LINE_W (12) | Address of the first-level victim |
| rsp_l2_evict | output | 1 | Second-level capacity victim evicted |
| rsp_l2_evict_addr | output | LINE_W (12) | Address of the second-level victim |
| rsp_backinv | output | 1 | Second-level victim removed from the first level |

## Verification
The bench aims at a line that is hit repeatedly in the first level while fresh lines stream through. Because first-level hits leave second-level recency alone, that line becomes the second-level victim. A design that skipped back-invalidation, or that refreshed the second level on a first-level hit, would then disagree on `rsp_backinv` or on the evicted address. The bench checks that the slot freed by back-invalidation takes the new line without a first-level eviction. A design that installed before invalidating would drop an extra, innocent line. The bench also revisits lines dropped by the first level and expects second-level hits, revisits second-level victims and expects memory fetches, and presents stray requests while busy. A design that accepted those would install lines the model never saw.

// File: rtl/incl_cache_pkg.sv
package incl_cache_pkg;
  localparam int unsigned LINE_W = 12;
  typedef logic [LINE_W-1:0] line_addr_t;
  typedef enum logic {SEQ_IDLE, SEQ_BUSY} seq_state_e;
endpackage

// File: rtl/incl_fa_lru.sv
module incl_fa_lru #(
  parameter int unsigned WAYS = 4,
  parameter int unsigned AW   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     lk_addr,
  input  logic              upd_en,
  input  logic              fill_en,
  input  logic              inv_en,
  input  logic [AW-1:0]     inv_addr,
  output logic              hit,
  output logic              inv_hit,
  output logic              vict_valid,
  output logic [AW-1:0]     vict_addr,
  output logic [WAYS-1:0]   vld_o,
  output logic [WAYS*AW-1:0] tags_o
);
  localparam int unsigned IW = (WAYS > 1) ? $clog2(WAYS) : 1;
  typedef logic [IW-1:0] idx_t;
  localparam idx_t OLDEST = idx_t'(WAYS - 1);

  logic [WAYS-1:0] vld, vld_nxt, hit_vec, inv_vec, vld_post;
  logic [AW-1:0]   tag [WAYS];
  idx_t            age [WAYS];
  idx_t            hit_idx, free_idx, old_idx, ins_idx, touch_idx;
  logic            free_found, do_touch, do_fill;

  // index of the single set bit of a one-hot vector
  function automatic idx_t oh_to_idx(input logic [WAYS-1:0] oh);
    idx_t r = '0;
    for (int i = 0; i < WAYS; i++) if (oh[i]) r = idx_t'(i);
    return r;
  endfunction

  // lowest-numbered clear bit
  function automatic idx_t lowest_clear(input logic [WAYS-1:0] v);
    idx_t r = '0;
    for (int i = WAYS - 1; i >= 0; i--) if (!v[i]) r = idx_t'(i);
    return r;
  endfunction

  always_comb begin
    for (int i = 0; i < WAYS; i++) begin
      hit_vec[i] = vld[i] && (tag[i] == lk_addr);
      inv_vec[i] = inv_en && vld[i] && (tag[i] == inv_addr);
    end
  end

  assign hit        = |hit_vec;
  assign inv_hit    = |inv_vec;
  assign hit_idx    = oh_to_idx(hit_vec);
  assign vld_post   = vld & ~inv_vec;
  assign free_found = ~&vld_post;
  assign free_idx   = lowest_clear(vld_post);

  always_comb begin
    old_idx = '0;
    for (int i = 0; i < WAYS; i++) if (age[i] == OLDEST) old_idx = idx_t'(i);
  end

  assign ins_idx    = free_found ? free_idx : old_idx;
  assign vict_valid = !free_found;
  assign vict_addr  = tag[old_idx];
  assign do_touch   = upd_en && (hit || fill_en);
  assign do_fill    = upd_en && !hit && fill_en;
  assign touch_idx  = hit ? hit_idx : ins_idx;

  always_comb begin
    vld_nxt = vld_post;
    if (do_fill) vld_nxt[ins_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < WAYS; i++) begin
        age[i] <= idx_t'(i);
        tag[i] <= '0;
      end
    end else begin
      vld <= vld_nxt;
      if (do_fill) tag[ins_idx] <= lk_addr;
      if (do_touch) begin
        for (int i = 0; i < WAYS; i++) begin
          if (idx_t'(i) == touch_idx) age[i] <= '0;
          else if (age[i] < age[touch_idx]) age[i] <= age[i] + idx_t'(1);
        end
      end
    end
  end

  assign vld_o = vld;
  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_tag_out
      assign tags_o[g*AW +: AW] = tag[g];
    end
  endgenerate
endmodule

// File: rtl/incl_seq.sv
module incl_seq #(
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          accept,
  output logic          upd,
  output logic [AW-1:0] cur_addr
);
  import incl_cache_pkg::*;
  seq_state_e st;

  assign req_ready = (st == SEQ_IDLE);
  assign accept    = req_valid && req_ready;
  assign upd       = (st == SEQ_BUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SEQ_IDLE;
      cur_addr <= '0;
    end else begin
      if (accept) begin
        st       <= SEQ_BUSY;
        cur_addr <= req_addr;
      end else if (upd) begin
        st <= SEQ_IDLE;
      end
    end
  end
endmodule

// File: rtl/incl_cache_tags.sv
module incl_cache_tags
  import incl_cache_pkg::*;
#(
  parameter int unsigned L1_WAYS = 4,
  parameter int unsigned L2_WAYS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LINE_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_hit_l1,
  output logic              rsp_hit_l2,
  output logic              rsp_miss,
  output logic              rsp_l1_fill,
  output logic              rsp_l2_fill,
  output logic              rsp_l1_evict,
  output logic [LINE_W-1:0] rsp_l1_evict_addr,
  output logic              rsp_l2_evict,
  output logic [LINE_W-1:0] rsp_l2_evict_addr,
  output logic              rsp_backinv
);
  logic                    acc_w, upd_w;
  line_addr_t              cur_addr;
  logic                    l1_hit, l2_hit, l1_inv_hit, l2_inv_hit_unused;
  logic                    l1_vict_v, l2_vict_v;
  line_addr_t              l1_vict_a, l2_vict_a;
  logic [L1_WAYS-1:0]      l1_vld_w;
  logic [L2_WAYS-1:0]      l2_vld_w;
  logic [L1_WAYS*LINE_W-1:0] l1_tags_w;
  logic [L2_WAYS*LINE_W-1:0] l2_tags_w;

  // named internal events
  logic ev_miss, ev_l2_only, ev_l1_fill, ev_l2_fill, ev_l1_drop, ev_l2_drop, ev_backinv;

  incl_seq #(.AW(LINE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .accept(acc_w), .upd(upd_w), .cur_addr(cur_addr)
  );

  assign ev_miss    = !l1_hit && !l2_hit;
  assign ev_l2_only = !l1_hit && l2_hit;
  assign ev_l1_fill = !l1_hit;
  assign ev_l2_fill = ev_miss;
  assign ev_l2_drop = ev_miss && l2_vict_v;
  assign ev_backinv = ev_l2_drop && l1_inv_hit;
  assign ev_l1_drop = !l1_hit && l1_vict_v;

  incl_fa_lru #(.WAYS(L1_WAYS), .AW(LINE_W)) u_l1 (
    .clk(clk), .rst_n(rst_n), .lk_addr(cur_addr),
    .upd_en(upd_w), .fill_en(1'b1),
    .inv_en(upd_w && ev_l2_drop), .inv_addr(l2_vict_a),
    .hit(l1_hit), .inv_hit(l1_inv_hit),
    .vict_valid(l1_vict_v), .vict_addr(l1_vict_a),
    .vld_o(l1_vld_w), .tags_o(l1_tags_w)
  );

  incl_fa_lru #(.WAYS(L2_WAYS), .AW(LINE_W)) u_l2 (
    .clk(clk), .rst_n(rst_n), .lk_addr(cur_addr),
    .upd_en(upd_w && !l1_hit), .fill_en(1'b1),
    .inv_en(1'b0), .inv_addr('0),
    .hit(l2_hit), .inv_hit(l2_inv_hit_unused),
    .vict_valid(l2_vict_v), .vict_addr(l2_vict_a),
    .vld_o(l2_vld_w), .tags_o(l2_tags_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;  rsp_hit_l1 <= 1'b0; rsp_hit_l2 <= 1'b0; rsp_miss <= 1'b0;
      rsp_l1_fill <= 1'b0; rsp_l2_fill <= 1'b0; rsp_l1_evict <= 1'b0; rsp_l2_evict <= 1'b0;
      rsp_l1_evict_addr <= '0; rsp_l2_evict_addr <= '0; rsp_backinv <= 1'b0;
    end else begin
      rsp_valid         <= upd_w;
      rsp_hit_l1        <= upd_w && l1_hit;
      rsp_hit_l2        <= upd_w && ev_l2_only;
      rsp_miss          <= upd_w && ev_miss;
      rsp_l1_fill       <= upd_w && ev_l1_fill;
      rsp_l2_fill       <= upd_w && ev_l2_fill;
      rsp_l1_evict      <= upd_w && ev_l1_drop;
      rsp_l1_evict_addr <= (upd_w && ev_l1_drop) ? l1_vict_a : '0;
      rsp_l2_evict      <= upd_w && ev_l2_drop;
      rsp_l2_evict_addr <= (upd_w && ev_l2_drop) ? l2_vict_a : '0;
      rsp_backinv       <= upd_w && ev_backinv;
    end
  end
endmodule

// File: rtl/incl_cache_tags_chk.sv
module incl_cache_tags_chk #(
  parameter int unsigned L1_WAYS = 4,
  parameter int unsigned L2_WAYS = 8,
  parameter int unsigned AW      = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                accept,
  input logic                req_ready,
  input logic                rsp_valid,
  input logic                rsp_hit_l1,
  input logic                rsp_hit_l2,
  input logic                rsp_miss,
  input logic                rsp_l1_fill,
  input logic                rsp_l2_fill,
  input logic                rsp_l1_evict,
  input logic                rsp_l2_evict,
  input logic                rsp_backinv,
  input logic [L1_WAYS-1:0]  l1_vld,
  input logic [L1_WAYS*AW-1:0] l1_tags,
  input logic [L2_WAYS-1:0]  l2_vld,
  input logic [L2_WAYS*AW-1:0] l2_tags
);
  logic incl_ok, found;

  always_comb begin
    incl_ok = 1'b1;
    found   = 1'b0;
    for (int i = 0; i < L1_WAYS; i++) begin
      found = 1'b0;
      for (int j = 0; j < L2_WAYS; j++)
        if (l2_vld[j] && (l2_tags[j*AW +: AW] == l1_tags[i*AW +: AW])) found = 1'b1;
      if (l1_vld[i] && !found) incl_ok = 1'b0;
    end
  end

  a_r9_inclusion: assert property (@(posedge clk) disable iff (!rst_n) incl_ok);
  a_r2_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !rsp_valid && !req_ready ##1 rsp_valid);
  a_r2_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit_l1, rsp_hit_l2, rsp_miss}) == 1);
  a_r4_l1_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit_l1) |-> !(rsp_l1_fill || rsp_l2_fill || rsp_l1_evict || rsp_l2_evict || rsp_backinv));
  a_r5_l2_hit_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit_l2) |-> rsp_l1_fill && !rsp_l2_fill && !rsp_l2_evict);
  a_r6_miss_fills: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> rsp_l1_fill && rsp_l2_fill);
  a_r8_backinv_slot: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_backinv |-> rsp_l2_evict && !rsp_l1_evict);
endmodule

bind incl_cache_tags incl_cache_tags_chk #(.L1_WAYS(L1_WAYS), .L2_WAYS(L2_WAYS), .AW(incl_cache_pkg::LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(acc_w), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_hit_l1(rsp_hit_l1), .rsp_hit_l2(rsp_hit_l2), .rsp_miss(rsp_miss),
  .rsp_l1_fill(rsp_l1_fill), .rsp_l2_fill(rsp_l2_fill), .rsp_l1_evict(rsp_l1_evict),
  .rsp_l2_evict(rsp_l2_evict), .rsp_backinv(rsp_backinv),
  .l1_vld(l1_vld_w), .l1_tags(l1_tags_w), .l2_vld(l2_vld_w), .l2_tags(l2_tags_w)
);

// File: tb/incl_cache_tags_tb.sv
module incl_cache_tags_tb;
  localparam int AW = 12;
  localparam int N1 = 4;
  localparam int N2 = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_hit_l1, rsp_hit_l2, rsp_miss;
  logic rsp_l1_fill, rsp_l2_fill, rsp_l1_evict, rsp_l2_evict, rsp_backinv;
  logic [AW-1:0] rsp_l1_evict_addr, rsp_l2_evict_addr;

  int checks = 0;
  int errors = 0;
  int backinv_seen = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  incl_cache_tags u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_hit_l1(rsp_hit_l1),
    .rsp_hit_l2(rsp_hit_l2), .rsp_miss(rsp_miss), .rsp_l1_fill(rsp_l1_fill),
    .rsp_l2_fill(rsp_l2_fill), .rsp_l1_evict(rsp_l1_evict),
    .rsp_l1_evict_addr(rsp_l1_evict_addr), .rsp_l2_evict(rsp_l2_evict),
    .rsp_l2_evict_addr(rsp_l2_evict_addr), .rsp_backinv(rsp_backinv)
  );

  // reference model: queues ordered most recent first
  logic [AW-1:0] m_l1[$];
  logic [AW-1:0] m_l2[$];

  // expected response
  bit e_h1, e_h2, e_m, e_f1, e_f2, e_d1, e_d2, e_bi;
  logic [AW-1:0] e_d1a, e_d2a;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int find_q(ref logic [AW-1:0] q[$], input logic [AW-1:0] a);
    for (int i = 0; i < q.size(); i++) if (q[i] == a) return i;
    return -1;
  endfunction

  task automatic model(input logic [AW-1:0] a);
    int p1, p2, pv;
    logic [AW-1:0] v;
    {e_h1, e_h2, e_m, e_f1, e_f2, e_d1, e_d2, e_bi} = '0;
    e_d1a = '0; e_d2a = '0;
    p1 = find_q(m_l1, a);
    p2 = find_q(m_l2, a);
    if (p1 >= 0) begin
      e_h1 = 1;
      m_l1.delete(p1); m_l1.push_front(a);
    end else begin
      e_f1 = 1;
      if (p2 >= 0) begin
        e_h2 = 1;
        m_l2.delete(p2); m_l2.push_front(a);
      end else begin
        e_m = 1; e_f2 = 1;
        if (m_l2.size() == N2) begin
          v = m_l2.pop_back();
          e_d2 = 1; e_d2a = v;
          pv = find_q(m_l1, v);
          if (pv >= 0) begin e_bi = 1; m_l1.delete(pv); end
        end
        m_l2.push_front(a);
      end
      if (m_l1.size() == N1) begin
        e_d1 = 1; e_d1a = m_l1.pop_back();
      end
      m_l1.push_front(a);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the response
  task automatic lookup(input logic [AW-1:0] a, input string lvl_tag,
                        input bit stray, input logic [AW-1:0] stray_a);
    req_valid = 1'b1; req_addr = a;
    model(a);
    @(negedge clk);
    if (stray) begin req_valid = 1'b1; req_addr = stray_a; end  // R10: ignored while busy
    else req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2", "ready while busy", req_ready, 0);
    chk(rsp_valid == 1'b0, "R2", "early rsp_valid", rsp_valid, 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R2", "rsp_valid", rsp_valid, 1);
    chk(req_ready == 1'b1, "R10", "ready after rsp", req_ready, 1);
    chk(rsp_hit_l1 == e_h1, lvl_tag, "hit_l1", rsp_hit_l1, e_h1);
    chk(rsp_hit_l2 == e_h2, lvl_tag, "hit_l2", rsp_hit_l2, e_h2);
    chk(rsp_miss == e_m, lvl_tag, "miss", rsp_miss, e_m);
    chk(rsp_l1_fill == e_f1, "R5", "l1_fill", rsp_l1_fill, e_f1);
    chk(rsp_l2_fill == e_f2, "R6", "l2_fill", rsp_l2_fill, e_f2);
    chk(rsp_l1_evict == e_d1, "R7", "l1_evict", rsp_l1_evict, e_d1);
    chk(rsp_l1_evict_addr == e_d1a, "R11", "l1_evict_addr", rsp_l1_evict_addr, e_d1a);
    chk(rsp_l2_evict == e_d2, "R8", "l2_evict", rsp_l2_evict, e_d2);
    chk(rsp_l2_evict_addr == e_d2a, "R11", "l2_evict_addr", rsp_l2_evict_addr, e_d2a);
    chk(rsp_backinv == e_bi, "R8", "backinv", rsp_backinv, e_bi);
    if (e_bi) backinv_seen++;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog act=%0d exp=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [AW-1:0] last_d2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    // R1: cold lookups all go to memory
    for (int k = 1; k <= 4; k++) lookup(AW'(k), "R1", 0, '0);
    lookup(12'd1, "R4", 0, '0);            // R4 first-level hit
    lookup(12'd5, "R6", 0, '0);            // R7 drops line 2
    lookup(12'd2, "R7", 0, '0);            // R7 dropped line still in L2
    // R10: stray request while busy must not install line 0x77
    lookup(12'd6, "R6", 1, 12'h077);
    lookup(12'h077, "R10", 0, '0);
    lookup(12'd7, "R6", 0, '0);
    lookup(12'd8, "R6", 0, '0);
    lookup(12'd9, "R6", 0, '0);
    last_d2 = e_d2a;
    lookup(last_d2, "R9", 0, '0);          // R9 L2 victim must miss
    // R8/R11: hot first-level line ages out of L2 and is back-invalidated
    lookup(12'h050, "R6", 0, '0);
    for (int k = 0; k < 10; k++) begin
      lookup(AW'(12'h100 + k), "R6", 0, '0);
      lookup(12'h050, "R11", 0, '0);
    end
    chk(backinv_seen > 0, "R8", "backinv observed", backinv_seen, 1);
    // mixed traffic
    lfsr = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      lookup(AW'(lfsr[3:0]), "R3", lfsr[7] && lfsr[6], AW'(12'h200 + lfsr[11:8]));
    end
    done = 1'b1;
    summary();
  end
endmodule